// File: doc/BRIEF.md
# Inverter Gate-Drive Protection Sequencer

This block sits between a PWM generator and a three-phase, six-switch gate driver. It takes three high-side and three low-side active-high switch commands and produces six gate enables. Between the commands and the enables it applies the protection rules. A low-side supply undervoltage turns off the lower switches. A bootstrap undervoltage on one phase turns off that phase's upper switch. A short-circuit trip turns off all lower switches together. The comparator flags arrive already synchronized as detect and release pulses.

A low-side supply undervoltage or a short-circuit trip drives a fault indication for a fixed number of clock cycles. The indication is an open-drain pull-down enable. A new event during the pulse starts the count again. After any protective shutdown, a channel only turns on again when its command makes a fresh low-to-high transition. This stops a switch from turning on by itself when protection clears while its command is still high.

Top module: `gate_prot_seq`

## Requirements
- R1: After reset, all six gate enables are 0, `fault_pull` is 0, and every channel is disarmed.
- R2: Once a channel is armed and no protection blocks it, its gate enable equals its command delayed by one clock. Bit i of `pwm_hi`/`gate_hi` is the upper switch of phase i, and bit i of `pwm_lo`/`gate_lo` is the lower switch of phase i.
- R3: A `ls_uv_det` pulse forces all three low-side enables to 0 from the next cycle and holds them off until `ls_uv_rst`. It also raises `fault_pull` for exactly FAULT_CYCLES cycles. The high-side enables are unaffected.
- R4: A `hs_uv_det[i]` pulse forces `gate_hi[i]` to 0 from the next cycle until `hs_uv_rst[i]`. The other phases are unaffected, and `fault_pull` stays 0.
- R5: A `sc_trip` pulse forces all three low-side enables to 0 in the next cycle and raises `fault_pull` for FAULT_CYCLES cycles. The high-side enables are unaffected.
- R6: While `fault_pull` is 1, no low-side enable is 1, even if its command rises.
- R7: When a pulse ends or an undervoltage is released, a channel whose command is still high stays off. It turns on one cycle after its next rising command edge.
- R8: A short-circuit or low-side undervoltage event while `fault_pull` is 1 restarts the pulse at its full width of FAULT_CYCLES cycles.
- R9: After reset, both supply domains count as undervoltage until their release pulse arrives. Outputs stay off until that release and a following rising command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 3 | High-side switch commands, one per phase |
| pwm_lo | input | 3 | Low-side switch commands, one per phase |
| ls_uv_det | input | 1 | Low-side supply undervoltage detect pulse |
| ls_uv_rst | input | 1 | Low-side supply undervoltage release pulse |
| hs_uv_det | input | 3 | Bootstrap undervoltage detect per phase |
| hs_uv_rst | input | 3 | Bootstrap undervoltage release per phase |
| sc_trip | input | 1 | Short-circuit trip pulse |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_pull | output | 1 | 1 = pull the open-drain fault line low |

## Verification
The bench sweeps all 64 command patterns on armed channels, which separates a correct bit-to-phase mapping and one-cycle latency from swapped or merged lanes. Each protection source is applied with every command held high. This shows which set of switches it removes and whether it raises the fault pulse. Commands are toggled during and after each pulse to tell a correct re-arm on a fresh edge apart from a level-sensitive restart. Pulse widths are counted both for a single event and for a second event inside the pulse, which exposes a timer that fails to reload.

// File: rtl/gate_prot_pkg.sv
package gate_prot_pkg;

  // Next value of the fault down-counter: reload on an event, else count to zero.
  function automatic int unsigned fault_next(input int unsigned cur,
                                             input logic trig,
                                             input int unsigned width);
    if (trig) return width;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Arm state of one channel given block, rising-edge and current arm.
  function automatic logic arm_next(input logic blk, input logic rise,
                                    input logic cur);
    if (blk) return 1'b0;
    if (rise) return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/prot_uv_flag.sv
module prot_uv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic rel,
  output logic active
);
  // Powers up in undervoltage; detect has priority over release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   active <= 1'b1;
    else if (det) active <= 1'b1;
    else if (rel) active <= 1'b0;
  end

  a_r9_det_sets: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> active);
endmodule

// File: rtl/prot_fault_timer.sv
module prot_fault_timer
  import gate_prot_pkg::*;
#(
  parameter int unsigned FAULT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  localparam int unsigned CW = $clog2(FAULT_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb cnt_d = CW'(fault_next(int'(cnt_q), trig, FAULT_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  a_r8_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == CW'(FAULT_CYCLES)));
  a_r3_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/prot_chan.sv
module prot_chan
  import gate_prot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic blk,
  output logic gate
);
  logic prev_q, arm_q, arm_d, rise;

  assign rise  = cmd & ~prev_q;
  assign arm_d = arm_next(blk, rise, arm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
      gate   <= 1'b0;
    end else begin
      prev_q <= cmd;
      arm_q  <= arm_d;
      gate   <= arm_d & cmd;
    end
  end

  a_r6_block_kills: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> !gate);
  a_r7_on_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> arm_q);
  a_r7_fresh_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && cmd) ##1 (!blk && cmd) |-> !gate [*1] ##1 1'b1);
endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
#(
  parameter int unsigned PHASES       = 3,
  parameter int unsigned FAULT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] pwm_hi,
  input  logic [PHASES-1:0] pwm_lo,
  input  logic              ls_uv_det,
  input  logic              ls_uv_rst,
  input  logic [PHASES-1:0] hs_uv_det,
  input  logic [PHASES-1:0] hs_uv_rst,
  input  logic              sc_trip,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              fault_pull
);
  logic              ls_uv_act;
  logic [PHASES-1:0] hs_uv_act;
  logic              fault_evt;
  logic              fault_busy;
  logic              lo_block;
  logic [PHASES-1:0] hi_block;

  assign fault_evt = ls_uv_det | sc_trip;
  assign lo_block  = fault_evt | ls_uv_act | fault_busy;

  prot_uv_flag u_ls_uv (
    .clk(clk), .rst_n(rst_n), .det(ls_uv_det), .rel(ls_uv_rst),
    .active(ls_uv_act)
  );

  prot_fault_timer #(.FAULT_CYCLES(FAULT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .trig(fault_evt), .busy(fault_busy)
  );

  assign fault_pull = fault_busy;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    prot_uv_flag u_hs_uv (
      .clk(clk), .rst_n(rst_n), .det(hs_uv_det[p]), .rel(hs_uv_rst[p]),
      .active(hs_uv_act[p])
    );
    assign hi_block[p] = hs_uv_det[p] | hs_uv_act[p];

    prot_chan u_hi (
      .clk(clk), .rst_n(rst_n), .cmd(pwm_hi[p]), .blk(hi_block[p]),
      .gate(gate_hi[p])
    );
    prot_chan u_lo (
      .clk(clk), .rst_n(rst_n), .cmd(pwm_lo[p]), .blk(lo_block),
      .gate(gate_lo[p])
    );

    a_r4_hs_uv_own: assert property (@(posedge clk) disable iff (!rst_n)
      hs_uv_det[p] |=> !gate_hi[p]);
  end

  a_r3_ls_uv_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
    ls_uv_det |=> (gate_lo == '0) && fault_pull);
  a_r5_sc_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
    sc_trip |=> (gate_lo == '0) && fault_pull);
  a_r6_no_lo_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pull |-> (gate_lo == '0));
  a_r4_hs_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_evt && !fault_busy) |=> !fault_pull);
endmodule

// File: tb/gate_prot_seq_tb_top.sv
module gate_prot_seq_tb_top;
  localparam int unsigned FW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pwm_hi = '0, pwm_lo = '0, hs_uv_det = '0, hs_uv_rst = '0;
  logic       ls_uv_det = 1'b0, ls_uv_rst = 1'b0, sc_trip = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       fault_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gate_prot_seq #(.PHASES(3), .FAULT_CYCLES(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .ls_uv_det(ls_uv_det), .ls_uv_rst(ls_uv_rst),
    .hs_uv_det(hs_uv_det), .hs_uv_rst(hs_uv_rst), .sc_trip(sc_trip),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_pull(fault_pull)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_fault(output int n);
    n = 0;
    while (fault_pull && n < 100) begin n++; tick(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    pwm_hi = 3'b111; pwm_lo = 3'b111;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    // R1 R9: reset state and still in undervoltage
    chk("R1 gate_hi", gate_hi, 0);
    chk("R1 gate_lo", gate_lo, 0);
    chk("R1 fault", fault_pull, 0);
    // R9: release both domains with commands held high: stays off
    ls_uv_rst = 1; hs_uv_rst = 3'b111; tick();
    ls_uv_rst = 0; hs_uv_rst = 0; tick(); tick();
    chk("R9 no edge hi", gate_hi, 0);
    chk("R9 no edge lo", gate_lo, 0);
    chk("R9 no fault", fault_pull, 0);
    pwm_hi = 0; pwm_lo = 0; tick();
    pwm_hi = 3'b111; pwm_lo = 3'b111; tick();
    chk("R9 edge hi", gate_hi, 7);
    chk("R9 edge lo", gate_lo, 7);

    // R2: exhaustive sweep of command patterns
    for (int p = 0; p < 64; p++) begin
      pwm_hi = p[5:3]; pwm_lo = p[2:0]; tick();
      chk("R2 hi", gate_hi, p[5:3]);
      chk("R2 lo", gate_lo, p[2:0]);
    end

    // R4: bootstrap undervoltage on each phase
    for (int ph = 0; ph < 3; ph++) begin
      pwm_hi = 3'b111; pwm_lo = 3'b111; tick();
      hs_uv_det[ph] = 1; tick();
      hs_uv_det[ph] = 0;
      chk("R4 own phase off", gate_hi, 7 & ~(1 << ph));
      chk("R4 low side kept", gate_lo, 7);
      chk("R4 no fault", fault_pull, 0);
      hs_uv_rst[ph] = 1; tick(); hs_uv_rst[ph] = 0; tick();
      chk("R7 hs needs edge", gate_hi, 7 & ~(1 << ph));
      pwm_hi[ph] = 0; tick(); pwm_hi[ph] = 1; tick();
      chk("R7 hs rearmed", gate_hi, 7);
    end

    // R5 R6: short circuit with toggles during pulse
    pwm_hi = 3'b111; pwm_lo = 3'b111; tick();
    sc_trip = 1; tick(); sc_trip = 0;
    chk("R5 lo off", gate_lo, 0);
    chk("R5 hi kept", gate_hi, 7);
    chk("R5 fault", fault_pull, 1);
    n = 0;
    while (fault_pull && n < 100) begin
      n++;
      if (gate_lo != 0) chk("R6 lo off in pulse", gate_lo, 0);
      if (n == 2) pwm_lo = 0;
      if (n == 4) pwm_lo = 3'b111;
      tick();
    end
    chk("R5 pulse width", n, FW);
    chk("R6 lo stayed off", gate_lo, 0);
    tick();
    chk("R7 sc needs edge", gate_lo, 0);
    pwm_lo = 0; tick(); pwm_lo = 3'b111; tick();
    chk("R7 sc rearmed", gate_lo, 7);

    // R3: low-side supply undervoltage
    ls_uv_det = 1; tick(); ls_uv_det = 0;
    chk("R3 lo off", gate_lo, 0);
    chk("R3 hi kept", gate_hi, 7);
    count_fault(n);
    chk("R3 pulse width", n, FW);
    pwm_lo = 0; tick(); pwm_lo = 3'b111; tick();
    chk("R3 held while uv", gate_lo, 0);
    ls_uv_rst = 1; tick(); ls_uv_rst = 0; tick();
    chk("R7 uv release needs edge", gate_lo, 0);
    pwm_lo = 3'b010; tick(); pwm_lo = 3'b111; tick();
    chk("R7 uv rearm partial", gate_lo, 3'b101);

    // R8: retrigger inside pulse restarts full width
    sc_trip = 1; tick(); sc_trip = 0;
    repeat (3) tick();
    chk("R8 still active", fault_pull, 1);
    ls_uv_det = 1; tick(); ls_uv_det = 0;
    count_fault(n);
    chk("R8 restarted width", n, FW);
    chk("R8 lo off", gate_lo, 0);

    finish_run();
  end
endmodule